// File: doc/BRIEF.md
# External Interrupt Request Latch

This block turns one active-low external interrupt line into a held request for a processor. The line is brought into the clock domain through a flop chain. A high-to-low transition of the resynchronised level sets a pending flag. The flag is forwarded as an interrupt request unless a mask bit blocks it. The processor's vector lookup always uses the fixed address the block drives on `irq_vector`.

Two clearing schemes are available. In edge mode, any acknowledge clears the flag on the next clock. The acknowledge can be the processor's vector-fetch strobe or a software write of the acknowledge bit. In level mode, the flag clears only when two things have both happened, in either order: an acknowledge, and the line being back high. An acknowledge seen while the line is low is remembered until the line rises. Software reads the control fields, the pending flag and the resynchronised line level through the same register port that it writes.

Top module: `ext_irq_latch`

## Requirements
- R1: After reset, pending is 0, the mask bit is 1, the mode bit is 0 and `irq_req` is low. With the line idle high, `reg_rdata` reads 0x12.
- R2: A 1-to-0 change of the resynchronised line sets pending. With the default two-flop chain, pending reads 1 on the third clock after the line is first sampled low. Holding the line low produces no further edge.
- R3: In edge mode (bit 0 = 0), `vec_ack` or a register write with bit 2 = 1 clears pending on the next clock, even while the line stays low.
- R4: In level mode (bit 0 = 1), an acknowledge given while the line is low leaves pending set. Pending then clears on the clock after the resynchronised line is seen high.
- R5: In level mode, if the line returns high without an acknowledge, pending stays set. A later acknowledge clears it on the next clock.
- R6: A falling edge in the same cycle as an acknowledge leaves pending set.
- R7: `irq_req` is high exactly when pending is 1 and the mask bit (bit 1) is 0.
- R8: A register write loads bit 0 as mode and bit 1 as mask. Bit 2 is a write-only acknowledge. The read word carries mode at bit 0 and mask at bit 1. Bit 2 reads 0, pending is at bit 3, and the resynchronised line is at bit 4. The upper bits read 0.
- R9: `irq_vector` constantly drives 0xFFFA.
- R10: An acknowledge given while nothing is pending is ignored. A request that arrives later is not cleared by that acknowledge when the line rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line_n | input | 1 | External active-low interrupt line, asynchronous |
| vec_ack | input | 1 | One-cycle strobe from the processor when it fetches this vector |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 3 | Write data: bit 0 mode, bit 1 mask, bit 2 acknowledge |
| reg_rdata | output | 8 | Read word: mode, mask, 0, pending, line level, zeros |
| irq_req | output | 1 | Masked interrupt request to the processor |
| irq_vector | output | 16 | Fixed vector address |

## Verification
Two events can collide: a new falling edge and an acknowledge can reach the pending flag in the same clock. To provoke this, the bench first leaves a request pending and raises the line. It then lowers the line and pulses `vec_ack` exactly on the cycle the edge detector fires, which is two clocks after the line goes low. The bench passes if pending and `irq_req` are still 1 on the following cycle. A second pairing occurs in level mode: the remembered acknowledge and the line returning high meet in one clock. The bench checks that the flag survives the cycle where only the line is high and drops on the next cycle.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
   localparam int unsigned WR_W      = 3;
   localparam int unsigned B_MODE    = 0;
   localparam int unsigned B_MASK    = 1;
   localparam int unsigned B_ACK     = 2;
   localparam int unsigned B_PEND    = 3;
   localparam int unsigned B_LEVEL   = 4;
   localparam int unsigned MIN_RD_W  = 5;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic d_sync
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("eirq_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RST_VAL;
               else        chain_q[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= RST_VAL;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/eirq_edge.sv
module eirq_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic fall
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= level;
   end

   assign fall = prev_q & ~level;

   p_fall_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);
endmodule

// File: rtl/eirq_latch.sv
module eirq_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_mode,
   input  logic fall,
   input  logic line_hi,
   input  logic ack,
   output logic pending
);
   logic pend_q, pend_d;
   logic armed_q, armed_d;

   always_comb begin
      pend_d  = pend_q;
      armed_d = armed_q;
      if (fall) begin
         pend_d  = 1'b1;
         armed_d = 1'b0;
      end else if (!lvl_mode) begin
         armed_d = 1'b0;
         if (ack) pend_d = 1'b0;
      end else if (pend_q && (ack || armed_q)) begin
         if (line_hi) begin
            pend_d  = 1'b0;
            armed_d = 1'b0;
         end else begin
            armed_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         pend_q  <= pend_d;
         armed_q <= armed_d;
      end
   end

   assign pending = pend_q;

   p_fall_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> pending);
   p_edge_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl_mode && ack && !fall) |=> !pending);
   p_level_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_mode && !line_hi && pending) |=> pending);
   p_no_stale_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !ack && !armed_q) |=> pending);
   p_collide_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && ack) |=> pending);
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RD_W        = 8,
   parameter int unsigned VEC_W       = 16,
   parameter logic [15:0] VECTOR_ADDR = 16'hFFFA
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     irq_line_n,
   input  logic                     vec_ack,
   input  logic                     reg_wr,
   input  logic [eirq_pkg::WR_W-1:0] reg_wdata,
   output logic [RD_W-1:0]          reg_rdata,
   output logic                     irq_req,
   output logic [VEC_W-1:0]         irq_vector
);
   import eirq_pkg::*;

   localparam int unsigned PAD_W = RD_W - MIN_RD_W;

   generate
      if (RD_W < MIN_RD_W) begin : g_bad_rd
         $error("ext_irq_latch: RD_W too narrow for the read fields");
      end
      if (VEC_W != 16) begin : g_bad_vec
         $error("ext_irq_latch: VEC_W must be 16");
      end
   endgenerate

   logic line_sync, fall, pending, ack;
   logic mode_q, mask_q;

   eirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(irq_line_n), .d_sync(line_sync));

   eirq_edge u_edge (
      .clk(clk), .rst_n(rst_n), .level(line_sync), .fall(fall));

   assign ack = vec_ack | (reg_wr & reg_wdata[B_ACK]);

   eirq_latch u_latch (
      .clk(clk), .rst_n(rst_n), .lvl_mode(mode_q), .fall(fall),
      .line_hi(line_sync), .ack(ack), .pending(pending));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         mask_q <= 1'b1;
      end else if (reg_wr) begin
         mode_q <= reg_wdata[B_MODE];
         mask_q <= reg_wdata[B_MASK];
      end
   end

   always_comb begin
      reg_rdata          = '0;
      reg_rdata[B_MODE]  = mode_q;
      reg_rdata[B_MASK]  = mask_q;
      reg_rdata[B_PEND]  = pending;
      reg_rdata[B_LEVEL] = line_sync;
   end

   assign irq_req    = pending & ~mask_q;
   assign irq_vector = VECTOR_ADDR;

   p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q |-> !irq_req);
   p_wr_loads_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> (reg_rdata[B_MODE] == $past(reg_wdata[B_MODE])) &&
                 (reg_rdata[B_MASK] == $past(reg_wdata[B_MASK])));
   p_pad_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (PAD_W == 0) || (reg_rdata[RD_W-1:MIN_RD_W] == '0));
endmodule

// File: tb/tb_ext_irq_latch.sv
module tb_ext_irq_latch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_line_n = 1'b1;
   logic        vec_ack = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_wdata = 3'd0;
   logic [7:0]  reg_rdata;
   logic        irq_req;
   logic [15:0] irq_vector;

   int cyc = 0;
   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   typedef struct {
      int         at;
      logic [7:0] rd;
      logic       req;
      string      tag;
   } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ext_irq_latch dut (
      .clk(clk), .rst_n(rst_n), .irq_line_n(irq_line_n), .vec_ack(vec_ack),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_req(irq_req), .irq_vector(irq_vector));

   task automatic expect_at(input int dly, input logic [7:0] rd, input logic rq, input string tag);
      exp_t e;
      e.at = cyc + dly; e.rd = rd; e.req = rq; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] d);
      reg_wr = 1'b1; reg_wdata = d;
      tick(1);
      reg_wr = 1'b0; reg_wdata = 3'd0;
   endtask

   task automatic vack();
      vec_ack = 1'b1;
      tick(1);
      vec_ack = 1'b0;
   endtask

   // monitor: pops expectations whose cycle has come
   initial begin
      forever begin
         @(negedge clk);
         while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (e.at != cyc || reg_rdata !== e.rd || irq_req !== e.req) begin
               n_err++;
               $display("FAIL %s cyc=%0d: rdata=%h req=%b expected rdata=%h req=%b",
                        e.tag, cyc, reg_rdata, irq_req, e.rd, e.req);
            end
            n_chk++;
            if (irq_vector !== 16'hFFFA) begin
               n_err++;
               $display("FAIL R9: vector=%h expected FFFA", irq_vector);
            end
         end
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      expect_at(1, 8'h12, 1'b0, "R1 reset state");
      tick(3);
      // R8: edge mode, unmasked
      expect_at(1, 8'h10, 1'b0, "R8 write mode/mask");
      wr(3'b000);
      tick(1);
      // R2: falling edge sets pending
      expect_at(2, 8'h00, 1'b0, "R8 line level bit");
      expect_at(3, 8'h08, 1'b1, "R2 edge sets");
      irq_line_n = 1'b0;
      tick(4);
      // R3: vector ack clears while line low, no re-set
      expect_at(1, 8'h00, 1'b0, "R3 vec ack clears");
      expect_at(4, 8'h00, 1'b0, "R2 no second edge while low");
      vack();
      tick(4);
      // R3: software ack clears
      irq_line_n = 1'b1; tick(3);
      expect_at(3, 8'h08, 1'b1, "R2 new edge after ack");
      irq_line_n = 1'b0; tick(3);
      expect_at(1, 8'h00, 1'b0, "R3 sw ack clears");
      wr(3'b100);
      tick(2);
      // R6: edge coincides with ack
      irq_line_n = 1'b1; tick(3);
      irq_line_n = 1'b0; tick(3);            // pending set again
      irq_line_n = 1'b1; tick(3);
      irq_line_n = 1'b0; tick(2);            // fall active now
      expect_at(1, 8'h08, 1'b1, "R6 edge beats ack");
      vack();
      tick(2);
      expect_at(1, 8'h00, 1'b0, "R3 clear after collision");
      vack();
      tick(1);
      irq_line_n = 1'b1; tick(3);
      // R4: level mode, ack while low
      expect_at(1, 8'h11, 1'b0, "R8 level mode set");
      wr(3'b001);
      tick(1);
      expect_at(3, 8'h09, 1'b1, "R2 edge in level mode");
      irq_line_n = 1'b0; tick(4);
      expect_at(1, 8'h09, 1'b1, "R4 ack while low keeps");
      expect_at(4, 8'h09, 1'b1, "R4 still pending while low");
      vack();
      tick(4);
      expect_at(2, 8'h19, 1'b1, "R4 line high seen, not yet clear");
      expect_at(3, 8'h11, 1'b0, "R4 remembered ack clears");
      irq_line_n = 1'b1; tick(4);
      // R5: line high first, then ack
      irq_line_n = 1'b0; tick(4);
      expect_at(2, 8'h19, 1'b1, "R5 high without ack");
      expect_at(5, 8'h19, 1'b1, "R5 still pending");
      irq_line_n = 1'b1; tick(5);
      expect_at(1, 8'h11, 1'b0, "R5 ack clears");
      wr(3'b101);
      tick(2);
      // R10: ack with nothing pending is ignored
      expect_at(1, 8'h11, 1'b0, "R10 idle ack");
      vack();
      tick(2);
      expect_at(3, 8'h09, 1'b1, "R10 new request");
      irq_line_n = 1'b0; tick(4);
      expect_at(4, 8'h19, 1'b1, "R10 no stale clear");
      irq_line_n = 1'b1; tick(4);
      expect_at(1, 8'h11, 1'b0, "R5 ack after rise");
      vack();
      tick(2);
      // R7: mask blocks request
      expect_at(1, 8'h13, 1'b0, "R8 mask set");
      wr(3'b011);
      tick(1);
      expect_at(3, 8'h0B, 1'b0, "R7 masked pending");
      irq_line_n = 1'b0; tick(4);
      expect_at(1, 8'h09, 1'b1, "R7 unmask raises req");
      wr(3'b001);
      tick(3);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done && sb.size() == 0);
         end
         begin
            tick(5000);
            n_chk++; n_err++;
            $display("FAIL watchdog: run did not finish, expected completion");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule